// File: doc/BRIEF.md
# Scratchpad Write and Authorized Copy Controller

This block is the memory-command layer that sits above a single-wire serial link. The link layer turns bit slots into bytes. This block takes in those received bytes and answers byte-sized read requests. It runs four commands: write to the scratchpad, read back the scratchpad, copy the scratchpad into the main memory array, and stream the memory array. It holds a 16-bit target address, an ending-offset and status byte, a 32-byte scratchpad and a 512-byte internal memory.

Data always reaches memory in two stages. The master first fills the scratchpad. It then reads back the address and status, or works them out, and returns those three bytes unchanged with the copy command. Only an exact echo starts the copy, which moves one byte per clock cycle. A reset from the link is not acted on until the copy finishes. A full-length scratchpad write returns a complemented CRC16 to the master, and a trailing fragment of a byte is flagged rather than stored.

Top module: `os_sp_ctrl`

## Requirements
- R1: Command 0Fh takes the low address byte, then the high address byte, then data. Each whole data byte is stored at scratchpad offset TA[4:0] plus its index, and the ending offset is set to the offset of the last whole byte stored.
- R2: Receiving the high address byte of command 0Fh clears the authorization flag (status bit 7) and the partial flag (status bit 5).
- R3: A byte flagged as incomplete during a scratchpad write is not stored, sets the partial flag, and ends the data phase.
- R4: When the byte at offset 1Fh is stored, the next two reads return the complement of the CRC16 (polynomial x^16+x^15+x^2+1, bit-reflected, starting from zero, fed least significant bit first). The low byte comes first. The CRC covers the command byte, both address bytes as received, and every data byte. Reads that come before offset 1Fh is reached, and reads after the CRC, return FFh.
- R5: Command AAh returns the low address byte, the high address byte and the status byte. The status byte holds bit 7 = authorization, bit 6 = 0, bit 5 = partial, and bits 4:0 = ending offset. Then come the scratchpad bytes from TA[4:0] through 1Fh, and then FFh.
- R6: Command 5Ah followed by bytes equal to the low address, the high address and the status byte, in that order, sets the authorization flag. It then writes scratchpad bytes from TA[4:0] through the ending offset into memory, starting at the target address.
- R7: If any of the three authorization bytes differs, nothing is copied, the flags stay unchanged, and every later read returns FFh until a link reset.
- R8: While a copy runs, copy_busy is high, a link reset has no effect, and reads return 00h. After the copy ends, reads return 55h until a link reset.
- R9: Command F0h takes two address bytes and then streams memory bytes from that address up to the last location, after which reads return FFh. The status byte is not changed.
- R10: Every read request is answered on the following cycle with rd_valid high for exactly one cycle. After reset, copy_busy is low and a read returns FFh.
- R11: Address bits at and above the memory address width are forced to zero as the high address byte is loaded, for both the write and the memory-read commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low synchronous reset |
| link_reset | input | 1 | One-cycle pulse: a reset was seen on the wire |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_partial | input | 1 | The present byte ended before its eighth bit |
| rx_byte | input | 8 | Received byte, bit 0 first on the wire |
| rd_req | input | 1 | The master wants the next byte |
| rd_valid | output | 1 | rd_data holds the answer to last cycle's request |
| rd_data | output | 8 | Byte returned to the master |
| copy_busy | output | 1 | A scratchpad-to-memory copy is in progress |

## Verification
A corrupted address, offset or flag shows up at the ports within three reads of a read-scratchpad command, because the header echoes all of them. A wrong scratchpad pointer shows up in the first data byte read back. A bad CRC register is seen in the two bytes that follow a full write. A copy loop that stops early or late, or starts at the wrong place, stays hidden until memory is streamed back. So the bench replays every page and every start offset and then compares the entire memory image.

// File: rtl/os_pkg.sv
package os_pkg;

   typedef enum logic [3:0] {
      ST_CMD, ST_WS_A1, ST_WS_A2, ST_WS_DAT, ST_WS_CRC,
      ST_RS,
      ST_CP_A1, ST_CP_A2, ST_CP_ES, ST_CP_RUN, ST_CP_DONE,
      ST_RM_A1, ST_RM_A2, ST_RM_DAT,
      ST_ONES
   } os_state_e;

   localparam logic [7:0] OP_WRITE_SP = 8'h0F;
   localparam logic [7:0] OP_READ_SP  = 8'hAA;
   localparam logic [7:0] OP_COPY_SP  = 8'h5A;
   localparam logic [7:0] OP_READ_MEM = 8'hF0;

   localparam logic [7:0] FILL_IDLE = 8'hFF;
   localparam logic [7:0] FILL_DONE = 8'h55;
   localparam logic [7:0] FILL_BUSY = 8'h00;

   // x^16 + x^15 + x^2 + 1, bit-reflected
   localparam logic [15:0] CRC_POLY_REV = 16'hA001;

endpackage

// File: rtl/os_crc16.sv
module os_crc16 #(
   parameter int          DW   = 8,
   parameter logic [15:0] POLY = 16'hA001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic          en,
   input  logic [DW-1:0] din,
   output logic [15:0]   crc
);

   logic [15:0] crc_q;
   logic [15:0] chain [DW+1];

   // ld restarts from a cleared generator and absorbs din in the same cycle
   assign chain[0] = ld ? 16'h0000 : crc_q;

   generate
      for (genvar i = 0; i < DW; i++) begin : g_bit
         logic fb;
         assign fb           = chain[i][0] ^ din[i];
         assign chain[i + 1] = (chain[i] >> 1) ^ (fb ? POLY : 16'h0000);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        crc_q <= 16'h0000;
      else if (ld || en) crc_q <= chain[DW];
   end

   assign crc = crc_q;

endmodule

// File: rtl/os_ram.sv
module os_ram #(
   parameter int AW = 5,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/os_sp_ctrl.sv
module os_sp_ctrl
   import os_pkg::*;
#(
   parameter int MEM_AW = 9,
   parameter int SP_AW  = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       link_reset,
   input  logic       rx_valid,
   input  logic       rx_partial,
   input  logic [7:0] rx_byte,
   input  logic       rd_req,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic       copy_busy
);

   localparam logic [15:0] TA_MASK = 16'((32'd1 << MEM_AW) - 32'd1);

   generate
      if (SP_AW < 1 || SP_AW > 5) begin : g_bad_sp
         $error("SP_AW must lie in 1..5 to fit the status byte");
      end
      if (MEM_AW < SP_AW || MEM_AW > 16) begin : g_bad_mem
         $error("MEM_AW must lie between SP_AW and 16");
      end
   endgenerate

   os_state_e         state;
   logic [15:0]       ta;
   logic [SP_AW-1:0]  e_off;
   logic [SP_AW-1:0]  sp_ptr;
   logic              pf;
   logic              aa;
   logic [MEM_AW-1:0] addr;
   logic [1:0]        phase;

   logic [7:0]        es_byte;
   logic [7:0]        sp_rdata;
   logic [7:0]        mem_rdata;
   logic [15:0]       crc_val;
   logic [15:0]       ta_next;
   logic              rx_go, rx_full;
   logic              sp_we, mem_we, crc_ld, crc_en;
   logic              sp_last, addr_last;

   assign rx_go     = rx_valid && !link_reset;
   assign rx_full   = rx_go && !rx_partial;
   assign ta_next   = {rx_byte, ta[7:0]} & TA_MASK;
   assign sp_last   = (sp_ptr == '1);
   assign addr_last = (addr == '1);

   always_comb begin
      es_byte            = 8'h00;
      es_byte[7]         = aa;
      es_byte[5]         = pf;
      es_byte[SP_AW-1:0] = e_off;
   end

   assign crc_ld    = rx_full && (state == ST_CMD) && (rx_byte == OP_WRITE_SP);
   assign crc_en    = rx_full && ((state == ST_WS_A1) || (state == ST_WS_A2) ||
                                  (state == ST_WS_DAT));
   assign sp_we     = rx_full && (state == ST_WS_DAT);
   assign mem_we    = (state == ST_CP_RUN);
   assign copy_busy = (state == ST_CP_RUN);

   os_crc16 #(.DW(8), .POLY(CRC_POLY_REV)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (crc_ld),
      .en    (crc_en),
      .din   (rx_byte),
      .crc   (crc_val)
   );

   os_ram #(.AW(SP_AW), .DW(8)) u_scratch (
      .clk   (clk),
      .we    (sp_we),
      .waddr (sp_ptr),
      .wdata (rx_byte),
      .raddr (sp_ptr),
      .rdata (sp_rdata)
   );

   os_ram #(.AW(MEM_AW), .DW(8)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (addr),
      .wdata (sp_rdata),
      .raddr (addr),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_CMD;
         ta       <= '0;
         e_off    <= '0;
         sp_ptr   <= '0;
         pf       <= 1'b0;
         aa       <= 1'b0;
         addr     <= '0;
         phase    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= FILL_IDLE;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= FILL_IDLE;

         if (link_reset && state != ST_CP_RUN) begin
            state <= ST_CMD;
         end else begin
            case (state)
               ST_CMD: if (rx_full) begin
                  case (rx_byte)
                     OP_WRITE_SP: state <= ST_WS_A1;
                     OP_READ_SP: begin
                        state  <= ST_RS;
                        phase  <= '0;
                        sp_ptr <= ta[SP_AW-1:0];
                     end
                     OP_COPY_SP:  state <= ST_CP_A1;
                     OP_READ_MEM: state <= ST_RM_A1;
                     default:     state <= ST_ONES;
                  endcase
               end

               ST_WS_A1: if (rx_full) begin
                  ta[7:0] <= rx_byte;
                  state   <= ST_WS_A2;
               end

               ST_WS_A2: if (rx_full) begin
                  ta     <= ta_next;
                  sp_ptr <= ta[SP_AW-1:0];
                  aa     <= 1'b0;
                  pf     <= 1'b0;
                  state  <= ST_WS_DAT;
               end

               ST_WS_DAT: begin
                  if (rx_go && rx_partial) begin
                     pf    <= 1'b1;
                     state <= ST_ONES;
                  end else if (rx_full) begin
                     e_off <= sp_ptr;
                     if (sp_last) begin
                        state <= ST_WS_CRC;
                        phase <= '0;
                     end else begin
                        sp_ptr <= sp_ptr + 1'b1;
                     end
                  end
               end

               ST_WS_CRC: if (rd_req) begin
                  rd_data <= phase[0] ? ~crc_val[15:8] : ~crc_val[7:0];
                  phase   <= phase + 2'd1;
                  if (phase[0]) state <= ST_ONES;
               end

               ST_RS: if (rd_req) begin
                  case (phase)
                     2'd0:    rd_data <= ta[7:0];
                     2'd1:    rd_data <= ta[15:8];
                     2'd2:    rd_data <= es_byte;
                     default: rd_data <= sp_rdata;
                  endcase
                  if (phase != 2'd3)  phase  <= phase + 2'd1;
                  else if (sp_last)   state  <= ST_ONES;
                  else                sp_ptr <= sp_ptr + 1'b1;
               end

               ST_CP_A1: if (rx_full)
                  state <= (rx_byte == ta[7:0]) ? ST_CP_A2 : ST_ONES;

               ST_CP_A2: if (rx_full)
                  state <= (rx_byte == ta[15:8]) ? ST_CP_ES : ST_ONES;

               ST_CP_ES: if (rx_full) begin
                  if (rx_byte == es_byte) begin
                     aa     <= 1'b1;
                     sp_ptr <= ta[SP_AW-1:0];
                     addr   <= ta[MEM_AW-1:0];
                     state  <= ST_CP_RUN;
                  end else begin
                     state <= ST_ONES;
                  end
               end

               ST_CP_RUN: begin
                  if (rd_req) rd_data <= FILL_BUSY;
                  addr   <= addr + 1'b1;
                  sp_ptr <= sp_ptr + 1'b1;
                  if (sp_ptr == e_off) state <= ST_CP_DONE;
               end

               ST_CP_DONE: if (rd_req) rd_data <= FILL_DONE;

               ST_RM_A1: if (rx_full) begin
                  ta[7:0] <= rx_byte;
                  state   <= ST_RM_A2;
               end

               ST_RM_A2: if (rx_full) begin
                  ta    <= ta_next;
                  addr  <= ta_next[MEM_AW-1:0];
                  state <= ST_RM_DAT;
               end

               ST_RM_DAT: if (rd_req) begin
                  rd_data <= mem_rdata;
                  if (addr_last) state <= ST_ONES;
                  else           addr  <= addr + 1'b1;
               end

               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/os_sp_ctrl_chk.sv
module os_sp_ctrl_chk
   import os_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      link_reset,
   input logic      rx_valid,
   input logic      rx_partial,
   input logic      rd_req,
   input logic      rd_valid,
   input logic      copy_busy,
   input logic      aa,
   input logic      pf,
   input logic      sp_we,
   input os_state_e state
);

   assert_read_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   assert_no_spurious_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   assert_write_clears_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WS_A2 && rx_valid && !rx_partial && !link_reset) |=> (!aa && !pf));

   assert_partial_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WS_DAT && rx_valid && rx_partial && !link_reset) |=> (pf && state == ST_ONES));

   assert_copy_sets_aa_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(copy_busy) |-> aa);

   assert_scratch_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      copy_busy |-> !sp_we);

   assert_reset_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_busy && link_reset) |=> (copy_busy || state == ST_CP_DONE));

endmodule

bind os_sp_ctrl os_sp_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .link_reset (link_reset),
   .rx_valid   (rx_valid),
   .rx_partial (rx_partial),
   .rd_req     (rd_req),
   .rd_valid   (rd_valid),
   .copy_busy  (copy_busy),
   .aa         (aa),
   .pf         (pf),
   .sp_we      (sp_we),
   .state      (state)
);

// File: tb/os_sp_ctrl_tb.sv
module os_sp_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       link_reset;
   logic       rx_valid;
   logic       rx_partial;
   logic [7:0] rx_byte;
   logic       rd_req;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       copy_busy;

   always #10 clk = ~clk;

   os_sp_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_reset (link_reset),
      .rx_valid   (rx_valid),
      .rx_partial (rx_partial),
      .rx_byte    (rx_byte),
      .rd_req     (rd_req),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .copy_busy  (copy_busy)
   );

   int         checks   = 0;
   int         failures = 0;
   int         salt     = 0;
   logic [7:0] sp_m  [32];
   logic [7:0] mem_m [512];
   logic [15:0] ta_m = 16'h0000;
   logic [7:0]  es_m = 8'h00;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {8'h00, b};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
      return r;
   endfunction

   task automatic tx(input logic [7:0] b, input bit part = 1'b0);
      rx_byte = b; rx_partial = part; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_partial = 1'b0;
   endtask

   task automatic rd(output logic [7:0] b);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      b = rd_data;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] exp);
      logic [7:0] b;
      rd(b);
      check(req, b, exp);
   endtask

   task automatic bus_rst();
      link_reset = 1'b1;
      @(negedge clk);
      link_reset = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] lo, input logic [7:0] hi, input int n, input bit part);
      logic [15:0] c;
      int off;
      bus_rst();
      c = crc_step(16'h0000, 8'h0F);
      tx(8'h0F);
      tx(lo); c = crc_step(c, lo);
      tx(hi); c = crc_step(c, hi);
      ta_m = {hi, lo} & 16'h01FF;
      off  = int'(lo[4:0]);
      es_m[7] = 1'b0; es_m[5] = 1'b0;
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'(int'(lo) * 7 + i * 29 + salt);
         tx(b);
         c = crc_step(c, b);
         sp_m[off + i] = b;
         es_m[4:0] = 5'(off + i);
      end
      salt += 11;
      if (part) begin
         tx(8'hA5, 1'b1);
         es_m[5] = 1'b1;
      end
      if (off + n == 32 && !part) begin
         rd_chk("R4 crc low byte", ~c[7:0]);
         rd_chk("R4 crc high byte", ~c[15:8]);
         rd_chk("R4 ones after crc", 8'hFF);
      end else begin
         rd_chk("R4 no crc before end", 8'hFF);
      end
   endtask

   task automatic do_read_sp();
      bus_rst();
      tx(8'hAA);
      rd_chk("R5 TA low", ta_m[7:0]);
      rd_chk("R5 TA high", ta_m[15:8]);
      rd_chk("R5 status", es_m);
      for (int o = int'(ta_m[4:0]); o < 32; o++) rd_chk("R1 scratch data", sp_m[o]);
      rd_chk("R5 ones after scratch", 8'hFF);
   endtask

   task automatic do_copy(input logic [7:0] es_send, input bit reset_mid);
      bus_rst();
      tx(8'h5A);
      tx(ta_m[7:0]);
      tx(ta_m[15:8]);
      tx(es_send);
      if (es_send == es_m) begin
         int o;
         int a;
         check("R8 busy at copy start", copy_busy, 1);
         if (reset_mid) begin
            bus_rst();
            rd_chk("R8 busy read", 8'h00);
            check("R8 reset ignored", copy_busy, 1);
         end
         for (int w = 0; w < 40 && copy_busy; w++) @(negedge clk);
         check("R8 copy ends", copy_busy, 0);
         es_m[7] = 1'b1;
         o = int'(ta_m[4:0]);
         a = int'(ta_m[8:0]);
         for (int s = 0; s < 32; s++) begin
            mem_m[a] = sp_m[o];
            if (o == int'(es_m[4:0])) break;
            o = (o + 1) % 32;
            a = (a + 1) % 512;
         end
         rd_chk("R8 done pattern", 8'h55);
         rd_chk("R8 done pattern again", 8'h55);
      end else begin
         check("R7 no copy started", copy_busy, 0);
         rd_chk("R7 ones after mismatch", 8'hFF);
         rd_chk("R7 ones after mismatch again", 8'hFF);
      end
   endtask

   task automatic do_read_mem(input logic [15:0] a, input int n);
      int ea;
      bus_rst();
      tx(8'hF0);
      tx(a[7:0]);
      tx(a[15:8]);
      ea   = int'(a & 16'h01FF);
      ta_m = a & 16'h01FF;
      for (int i = 0; i < n; i++) rd_chk("R9 memory byte", mem_m[ea + i]);
      if (ea + n == 512) rd_chk("R9 ones after end", 8'hFF);
   endtask

   task automatic read_status(output logic [7:0] lo, output logic [7:0] hi, output logic [7:0] es);
      bus_rst();
      tx(8'hAA);
      rd(lo);
      rd(hi);
      rd(es);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] b, lo, hi, es;
      rst_n = 1'b0; link_reset = 1'b0; rx_valid = 1'b0; rx_partial = 1'b0;
      rx_byte = 8'h00; rd_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state and read handshake
      check("R10 busy low after reset", copy_busy, 0);
      check("R10 no answer without request", rd_valid, 0);
      rd(b);
      check("R10 answer valid", rd_valid, 1);
      check("R10 idle read value", b, 8'hFF);
      @(negedge clk);
      check("R10 answer lasts one cycle", rd_valid, 0);

      // Fill every page through the scratchpad (R1, R4, R6)
      for (int p = 0; p < 16; p++) begin
         do_write(8'(p * 32), 8'((p * 32) >> 8), 32, 1'b0);
         do_copy(es_m, 1'b0);
      end

      // Every start offset, page chosen from the offset
      for (int off = 0; off < 32; off++) begin
         int a;
         a = (off % 16) * 32 + off;
         do_write(8'(a), 8'(a >> 8), 32 - off, 1'b0);
         do_read_sp();
         do_copy(es_m, 1'b0);
         do_read_sp();
         check("R6 authorization flag set", es_m[7], 1);
      end
      do_read_mem(16'h0000, 512);

      // Short write: flags cleared, no CRC (R2, R4)
      do_write(8'hA3, 8'h00, 4, 1'b0);
      read_status(lo, hi, es);
      check("R2 flags cleared by write", es & 8'hE0, 8'h00);
      check("R1 ending offset", es[4:0], 5'd6);
      do_read_sp();

      // Partial last byte (R3), then mismatched and matching copies (R7, R6)
      do_write(8'h45, 8'h00, 3, 1'b1);
      read_status(lo, hi, es);
      check("R3 partial status", es, 8'h27);
      do_read_sp();
      do_copy(8'h07, 1'b0);
      read_status(lo, hi, es);
      check("R7 flags unchanged", es, 8'h27);
      do_read_mem(16'h0040, 32);
      do_copy(8'h27, 1'b0);
      do_read_mem(16'h0040, 32);

      // Address masking and reset during copy (R11, R8)
      do_write(8'hE0, 8'hFF, 32, 1'b0);
      read_status(lo, hi, es);
      check("R11 high address masked", hi, 8'h01);
      check("R11 low address kept", lo, 8'hE0);
      do_copy(es_m, 1'b1);
      do_read_mem(16'h01E0, 32);

      // Read memory leaves status alone (R9), masked read address (R11)
      do_read_mem(16'h01F0, 16);
      read_status(lo, hi, es);
      check("R9 status unchanged", es, es_m);
      check("R11 TA after memory read", {hi, lo}, 16'h01F0);
      do_read_mem(16'hFE10, 8);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule